// File: doc/BRIEF.md
# Memory-Table Multi-Line Serial Transmitter

This block drives up to sixteen asynchronous serial transmit lines. It holds no per-line buffer pointer or length locally. Each line owns one slot in each of two word tables in external memory. The first table holds the byte address of the next character to send. The second table holds how many characters remain. A per-line pending bit marks the lines that have output waiting. A small sequencer visits those lines in round-robin order through a single-access memory port. For each visit it reads the pointer word, then the length word, then the word that holds the character. It then writes back the advanced pointer and the reduced length, and hands the character to that line's shifter.

All lines share one bit rate, one character length (5 to 8 data bits) and one stop-bit setting (1 or 2). Software posts a buffer by filling in the two table slots and pulsing the line's set bit. When the last character of a buffer has been fetched, the pending bit drops and a sticky completion flag is raised. That flag becomes an interrupt request when the interrupt enable is high. A separate per-line input holds a line in the spacing state to send a break.

The table base input supplies the upper address byte, so both tables sit inside one 256-byte aligned window. The pointer table occupies bytes 0x00-0x1F of that window and the length table occupies bytes 0x20-0x3F.

Top module: `memtbl_serial_tx`

## Requirements
- R1: After reset, every serial output is high (marking), no line is pending, the completion flag and the interrupt request are low, and no memory request is issued.
- R2: One service of line L issues exactly these accesses, in this order: a read of the pointer slot at byte address {base,8'h00}+2L, a read of the length slot at {base,8'h20}+2L, a read of the word that holds the character, a write of the pointer slot, and a write of the length slot.
- R3: The character is read at the pointer with bit 0 cleared. When the pointer is even, the character is bits [7:0] of the returned word; when it is odd, the character is bits [15:8].
- R4: Each frame is one low start bit, then N = 5 + cfg_len_i data bits sent least significant bit first (bits above N are ignored), then one stop bit (cfg_stop2_i=0) or two stop bits (cfg_stop2_i=1), all high. Every bit lasts BIT_CYCLES clocks.
- R5: The pointer slot is written back with the pointer plus one and the length slot with the length minus one. After a buffer of C characters, the pointer slot holds start+C and the length slot holds 0.
- R6: When the length written back is 0, the line's pending bit clears and the completion flag sets in the same clock. The flag stays set until done_clr_i is pulsed. tx_irq_o equals the flag ANDed with tx_int_en_i.
- R7: If the length read for a pending line is 0, the line makes no further access, sends no frame, has its pending bit cleared and sets the completion flag.
- R8: Lines that are pending and whose shifter is idle are served in round-robin order, starting with the line after the one served last. A line whose shifter is busy is skipped.
- R9: A memory request holds its address, direction and write data stable until mem_ready_i is high, and only one access is outstanding at a time.
- R10: While brk_i[L] is high, txd_o[L] is low whatever that line is doing. Other lines are unaffected.
- R11: If act_set_i[L] is high in the same clock that the engine clears line L's pending bit, the line stays pending.
- R12: When memory answers every request in the same clock, consecutive frames of one buffer start exactly (2 + N + stop bits) x BIT_CYCLES clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_i | input | BASE_W | Upper address byte of the table window |
| cfg_len_i | input | 2 | Character length code, N = 5 + code |
| cfg_stop2_i | input | 1 | 1 selects two stop bits |
| tx_int_en_i | input | 1 | Transmit interrupt enable |
| act_set_i | input | NUM_LINES | Pulse to mark lines as pending |
| brk_i | input | NUM_LINES | Per-line break hold |
| done_clr_i | input | 1 | Clears the completion flag |
| mem_req_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address (word aligned) |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ready_i | input | 1 | Access accepted this clock; read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| active_o | output | NUM_LINES | Pending bits |
| done_o | output | 1 | Sticky completion flag |
| tx_irq_o | output | 1 | Transmit interrupt request |
| txd_o | output | NUM_LINES | Serial outputs |

## Verification
Two things can land on the same line in the same clock: software setting the pending bit, and the engine clearing it because the length it writes back is zero. The bench watches the memory port for the zero write to that line's length slot and pulses that line's set bit in the same clock. It then requires the pending bit to be high one clock later. After that it requires the line to be re-fetched, to hit the zero-length path, and to drop cleanly. Round-robin order is judged under a stalling memory, from the sequence of pointer-slot reads of two lines posted together.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_RD_PTR,
      SQ_RD_LEN,
      SQ_RD_CHR,
      SQ_WR_PTR,
      SQ_WR_LEN
   } seq_t;

   localparam int FRAME_W = 11;
   localparam int TICK_W  = 4;

   // frame image, sent from bit 0: start, data LSB first, then ones
   function automatic logic [FRAME_W-1:0] make_frame(input logic [7:0] chr,
                                                     input logic [1:0] len);
      logic [FRAME_W-1:0] f;
      f    = '1;
      f[0] = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (i < 5 + int'(len)) f[i+1] = chr[i];
      end
      return f;
   endfunction

   // bit slots of a frame plus one closing idle slot
   function automatic logic [TICK_W-1:0] frame_ticks(input logic [1:0] len,
                                                     input logic       stop2);
      return TICK_W'(8) + {2'b00, len} + {3'b000, stop2};
   endfunction

endpackage

// File: rtl/mtx_bitclk.sv
module mtx_bitclk #(
   parameter int BIT_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;

   logic [CW-1:0] div_q;

   assign tick = (div_q == CW'(BIT_CYCLES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)    div_q <= '0;
      else if (tick) div_q <= '0;
      else           div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/mtx_rr_pick.sv
module mtx_rr_pick #(
   parameter int NUM_LINES = 16,
   parameter int LINE_W    = 4
) (
   input  logic [NUM_LINES-1:0] req,
   input  logic [LINE_W-1:0]    last,
   output logic                 any,
   output logic [LINE_W-1:0]    pick
);
   always_comb begin
      any  = 1'b0;
      pick = '0;
      // farthest offset first so the nearest eligible line wins
      for (int i = NUM_LINES; i >= 1; i--) begin
         int j;
         j = (int'(last) + i) % NUM_LINES;
         if (req[j]) begin
            any  = 1'b1;
            pick = LINE_W'(j);
         end
      end
   end
endmodule

// File: rtl/mtx_tx_line.sv
module mtx_tx_line
   import mtx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       load,
   input  logic [7:0] chr,
   input  logic [1:0] len,
   input  logic       stop2,
   input  logic       brk,
   output logic       txd,
   output logic       busy
);
   logic [FRAME_W-1:0] frame_q;
   logic [TICK_W-1:0]  left_q;
   logic               lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '1;
         left_q  <= '0;
         lvl_q   <= 1'b1;
      end else if (load) begin
         frame_q <= make_frame(chr, len);
         left_q  <= frame_ticks(len, stop2);
      end else if (tick && left_q != '0) begin
         lvl_q   <= frame_q[0];
         frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
         left_q  <= left_q - 1'b1;
      end
   end

   assign busy = (left_q != '0);
   assign txd  = lvl_q & ~brk;
endmodule

// File: rtl/memtbl_serial_tx.sv
module memtbl_serial_tx
   import mtx_pkg::*;
#(
   parameter int NUM_LINES  = 16,
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int BASE_W     = 8,
   parameter int BIT_CYCLES = 8,
   parameter bit HI_FIRST   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BASE_W-1:0]    base_i,
   input  logic [1:0]           cfg_len_i,
   input  logic                 cfg_stop2_i,
   input  logic                 tx_int_en_i,
   input  logic [NUM_LINES-1:0] act_set_i,
   input  logic [NUM_LINES-1:0] brk_i,
   input  logic                 done_clr_i,
   output logic                 mem_req_o,
   output logic                 mem_we_o,
   output logic [ADDR_W-1:0]    mem_addr_o,
   output logic [DATA_W-1:0]    mem_wdata_o,
   input  logic                 mem_ready_i,
   input  logic [DATA_W-1:0]    mem_rdata_i,
   output logic [NUM_LINES-1:0] active_o,
   output logic                 done_o,
   output logic                 tx_irq_o,
   output logic [NUM_LINES-1:0] txd_o
);
   localparam int LINE_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
   localparam int SLOT_W  = 4;
   localparam int LOW_W   = ADDR_W - BASE_W;

   initial begin
      assert (NUM_LINES >= 2 && NUM_LINES <= 16)
         else $error("NUM_LINES must lie in 2..16");
      assert (LOW_W == 8)
         else $error("table window must be 256 bytes");
      assert (DATA_W == 16 && ADDR_W == DATA_W)
         else $error("pointer and data words must be 16 bits");
      assert (BIT_CYCLES >= 2)
         else $error("BIT_CYCLES must be at least 2");
   end

   seq_t                  state_q;
   logic [LINE_W-1:0]     cur_q, last_q, pick;
   logic                  any_ready;
   logic [DATA_W-1:0]     ptr_q, cnt_q;
   logic [7:0]            chr_q, chr_sel;
   logic [NUM_LINES-1:0]  act_q, busy_vec, clr_vec, load_vec;
   logic                  done_q, done_set, tick;
   logic [SLOT_W-1:0]     slot;
   logic [ADDR_W-1:0]     ptr_ent, len_ent;

   mtx_bitclk #(.BIT_CYCLES(BIT_CYCLES)) i_bitclk (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   mtx_rr_pick #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) i_pick (
      .req (act_q & ~busy_vec),
      .last(last_q),
      .any (any_ready),
      .pick(pick)
   );

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      mtx_tx_line i_line (
         .clk  (clk),
         .rst_n(rst_n),
         .tick (tick),
         .load (load_vec[g]),
         .chr  (chr_q),
         .len  (cfg_len_i),
         .stop2(cfg_stop2_i),
         .brk  (brk_i[g]),
         .txd  (txd_o[g]),
         .busy (busy_vec[g])
      );
   end

   if (HI_FIRST) begin : g_hi_first
      assign chr_sel = ptr_q[0] ? mem_rdata_i[7:0] : mem_rdata_i[15:8];
   end else begin : g_lo_first
      assign chr_sel = ptr_q[0] ? mem_rdata_i[15:8] : mem_rdata_i[7:0];
   end

   assign slot    = SLOT_W'(cur_q);
   assign ptr_ent = {base_i, 3'b000, slot, 1'b0};
   assign len_ent = {base_i, 3'b001, slot, 1'b0};

   always_comb begin
      mem_req_o   = (state_q != SQ_IDLE);
      mem_we_o    = (state_q == SQ_WR_PTR) || (state_q == SQ_WR_LEN);
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      unique case (state_q)
         SQ_RD_PTR: mem_addr_o = ptr_ent;
         SQ_RD_LEN: mem_addr_o = len_ent;
         SQ_RD_CHR: mem_addr_o = {ptr_q[ADDR_W-1:1], 1'b0};
         SQ_WR_PTR: begin
            mem_addr_o  = ptr_ent;
            mem_wdata_o = ptr_q + 1'b1;
         end
         SQ_WR_LEN: begin
            mem_addr_o  = len_ent;
            mem_wdata_o = cnt_q - 1'b1;
         end
         default: ;
      endcase
   end

   always_comb begin
      clr_vec  = '0;
      load_vec = '0;
      done_set = 1'b0;
      if (state_q == SQ_RD_LEN && mem_ready_i && mem_rdata_i == '0) begin
         clr_vec[cur_q] = 1'b1;
         done_set       = 1'b1;
      end
      if (state_q == SQ_WR_LEN && mem_ready_i) begin
         load_vec[cur_q] = 1'b1;
         if (cnt_q == DATA_W'(1)) begin
            clr_vec[cur_q] = 1'b1;
            done_set       = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cur_q   <= '0;
         last_q  <= LINE_W'(NUM_LINES - 1);
         ptr_q   <= '0;
         cnt_q   <= '0;
         chr_q   <= '0;
         act_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         act_q  <= (act_q & ~clr_vec) | act_set_i;
         done_q <= done_set | (done_q & ~done_clr_i);
         unique case (state_q)
            SQ_IDLE: if (any_ready) begin
               cur_q   <= pick;
               last_q  <= pick;
               state_q <= SQ_RD_PTR;
            end
            SQ_RD_PTR: if (mem_ready_i) begin
               ptr_q   <= mem_rdata_i;
               state_q <= SQ_RD_LEN;
            end
            SQ_RD_LEN: if (mem_ready_i) begin
               cnt_q   <= mem_rdata_i;
               state_q <= (mem_rdata_i == '0) ? SQ_IDLE : SQ_RD_CHR;
            end
            SQ_RD_CHR: if (mem_ready_i) begin
               chr_q   <= chr_sel;
               state_q <= SQ_WR_PTR;
            end
            SQ_WR_PTR: if (mem_ready_i) state_q <= SQ_WR_LEN;
            SQ_WR_LEN: if (mem_ready_i) state_q <= SQ_IDLE;
            default:   state_q <= SQ_IDLE;
         endcase
      end
   end

   assign active_o = act_q;
   assign done_o   = done_q;
   assign tx_irq_o = done_q & tx_int_en_i;
endmodule

// File: rtl/memtbl_serial_tx_chk.sv
module memtbl_serial_tx_chk #(
   parameter int NUM_LINES = 16,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] act_set_i,
   input logic [NUM_LINES-1:0] brk_i,
   input logic                 done_clr_i,
   input logic                 mem_req_o,
   input logic                 mem_we_o,
   input logic [ADDR_W-1:0]    mem_addr_o,
   input logic [DATA_W-1:0]    mem_wdata_o,
   input logic                 mem_ready_i,
   input logic [NUM_LINES-1:0] active_o,
   input logic                 done_o,
   input logic [NUM_LINES-1:0] txd_o
);
   // R9: a waiting request keeps its address, direction and data
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=>
         (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

   // R10: a held break keeps its lines low
   p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|brk_i) |-> ((txd_o & brk_i) == '0));

   // R6: completion flag is sticky until cleared
   p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !done_clr_i) |=> done_o);

   // R6: dropping a pending bit comes with the completion flag
   p_drop_sets_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(active_o) & ~active_o)) |-> done_o);

   // R11: a set pulse always leaves its lines pending
   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|act_set_i) |=> ((active_o & $past(act_set_i)) == $past(act_set_i)));
endmodule

bind memtbl_serial_tx memtbl_serial_tx_chk #(
   .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .act_set_i  (act_set_i),
   .brk_i      (brk_i),
   .done_clr_i (done_clr_i),
   .mem_req_o  (mem_req_o),
   .mem_we_o   (mem_we_o),
   .mem_addr_o (mem_addr_o),
   .mem_wdata_o(mem_wdata_o),
   .mem_ready_i(mem_ready_i),
   .active_o   (active_o),
   .done_o     (done_o),
   .txd_o      (txd_o)
);

// File: tb/test_memtbl_serial_tx.sv
module test_memtbl_serial_tx;
   localparam int NL = 16;
   localparam int BC = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    base_i = 8'h01;
   logic [1:0]    cfg_len_i = 2'd3;
   logic          cfg_stop2_i = 1'b0;
   logic          tx_int_en_i = 1'b0;
   logic [NL-1:0] act_set_i = '0;
   logic [NL-1:0] brk_i = '0;
   logic          done_clr_i = 1'b0;
   logic          mem_req_o, mem_we_o, mem_ready_i;
   logic [15:0]   mem_addr_o, mem_wdata_o, mem_rdata_i;
   logic [NL-1:0] active_o, txd_o;
   logic          done_o, tx_irq_o;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   logic stall = 1'b0;
   logic ph    = 1'b0;

   logic [15:0] mem [256];
   logic [15:0] log_a [64];
   logic        log_w [64];
   logic [15:0] log_d [64];
   int          log_n = 0;

   always #5 clk = ~clk;

   memtbl_serial_tx #(.NUM_LINES(NL), .BIT_CYCLES(BC)) i_memtbl_serial_tx (
      .clk(clk), .rst_n(rst_n), .base_i(base_i), .cfg_len_i(cfg_len_i),
      .cfg_stop2_i(cfg_stop2_i), .tx_int_en_i(tx_int_en_i),
      .act_set_i(act_set_i), .brk_i(brk_i), .done_clr_i(done_clr_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
      .mem_rdata_i(mem_rdata_i), .active_o(active_o), .done_o(done_o),
      .tx_irq_o(tx_irq_o), .txd_o(txd_o)
   );

   assign mem_ready_i = stall ? ph : 1'b1;
   assign mem_rdata_i = mem[mem_addr_o[8:1]];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      ph  <= ~ph;
      if (mem_req_o && mem_ready_i) begin
         if (mem_we_o) mem[mem_addr_o[8:1]] <= mem_wdata_o;
         if (log_n < 64) begin
            log_a[log_n] <= mem_addr_o;
            log_w[log_n] <= mem_we_o;
            log_d[log_n] <= mem_wdata_o;
            log_n        <= log_n + 1;
         end
      end
   end

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic post(input int l, input logic [15:0] a, input logic [15:0] c);
      mem[8'h80 + l] = a;
      mem[8'h90 + l] = c;
   endtask

   task automatic kick(input logic [NL-1:0] m);
      @(negedge clk) act_set_i = m;
      @(negedge clk) act_set_i = '0;
   endtask

   // sample one frame mid-bit; t = cycle of the falling start edge
   task automatic decode(input int l, input int nd, input int ns,
                         output logic [7:0] b, output int t, output logic ok);
      int w = 0;
      b  = '0;
      ok = 1'b1;
      do begin
         @(negedge clk);
         w++;
      end while (txd_o[l] != 1'b0 && w < 3000);
      t = cyc;
      if (w >= 3000) begin
         ok = 1'b0;
         return;
      end
      repeat (BC / 2) @(negedge clk);
      if (txd_o[l] != 1'b0) ok = 1'b0;
      for (int i = 0; i < nd; i++) begin
         repeat (BC) @(negedge clk);
         b[i] = txd_o[l];
      end
      for (int s = 0; s < ns; s++) begin
         repeat (BC) @(negedge clk);
         if (txd_o[l] != 1'b1) ok = 1'b0;
      end
   endtask

   // {len[1:0], stop2, odd, first byte, second byte}
   localparam logic [19:0] VEC [6] = '{
      {2'd3, 1'b0, 1'b0, 8'hA5, 8'h3C},
      {2'd0, 1'b1, 1'b1, 8'hFF, 8'h15},
      {2'd1, 1'b0, 1'b1, 8'h6B, 8'hC2},
      {2'd2, 1'b1, 1'b0, 8'h81, 8'h7E},
      {2'd3, 1'b1, 1'b1, 8'h00, 8'hFF},
      {2'd0, 1'b0, 1'b0, 8'h1E, 8'h0B}
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(txd_o == '1, "R1 txd idle", 32'(txd_o), 32'hFFFF);
      check(active_o == '0 && done_o == 1'b0 && tx_irq_o == 1'b0, "R1 flags",
            {15'd0, active_o, done_o}, 0);
      check(mem_req_o == 1'b0, "R1 no request", 32'(mem_req_o), 0);

      // vector walk: R2 R3 R4 R5 R6 R12
      for (int v = 0; v < 6; v++) begin
         logic [1:0]  lc;
         logic        s2, od;
         logic [7:0]  b0, b1, g0, g1, msk;
         logic [15:0] st;
         int nd, ns, t0, t1;
         logic ok0, ok1;
         {lc, s2, od, b0, b1} = VEC[v];
         nd  = 5 + int'(lc);
         ns  = 1 + int'(s2);
         msk = 8'((1 << nd) - 1);
         st  = 16'h0040 + 16'(od);
         mem[8'h20] = '0;
         mem[8'h21] = '0;
         if (od) begin
            mem[8'h20][15:8] = b0;
            mem[8'h21][7:0]  = b1;
         end else begin
            mem[8'h20] = {b1, b0};
         end
         post(v, st, 16'd2);
         cfg_len_i   = lc;
         cfg_stop2_i = s2;
         tx_int_en_i = v[0];
         @(negedge clk) done_clr_i = 1'b1;
         @(negedge clk) done_clr_i = 1'b0;
         log_n = 0;
         kick(NL'(1) << v);
         decode(v, nd, ns, g0, t0, ok0);
         decode(v, nd, ns, g1, t1, ok1);
         check(g0 == (b0 & msk), "R4 R3 first char", 32'(g0), 32'(b0 & msk));
         check(g1 == (b1 & msk), "R4 R3 second char", 32'(g1), 32'(b1 & msk));
         check(ok0 && ok1, "R4 start and stop levels", 32'({ok0, ok1}), 3);
         check(t1 - t0 == (2 + nd + ns) * BC, "R12 frame spacing",
               32'(t1 - t0), 32'((2 + nd + ns) * BC));
         check(log_a[0] == 16'h0100 + 16'(2 * v) && !log_w[0], "R2 pointer read",
               32'(log_a[0]), 32'h100 + 32'(2 * v));
         check(log_a[1] == 16'h0120 + 16'(2 * v) && !log_w[1], "R2 length read",
               32'(log_a[1]), 32'h120 + 32'(2 * v));
         check(log_a[2] == 16'h0040 && !log_w[2], "R3 aligned char read",
               32'(log_a[2]), 32'h40);
         check(log_w[3] && log_d[3] == st + 16'd1, "R5 pointer write",
               32'(log_d[3]), 32'(st + 16'd1));
         check(log_w[4] && log_d[4] == 16'd1, "R5 length write", 32'(log_d[4]), 1);
         check(mem[8'h80 + v] == st + 16'd2 && mem[8'h90 + v] == 16'd0,
               "R5 final table", 32'(mem[8'h80 + v]), 32'(st + 16'd2));
         check(active_o[v] == 1'b0 && done_o == 1'b1, "R6 completion",
               {30'd0, active_o[v], done_o}, 1);
         check(tx_irq_o == v[0], "R6 interrupt gate", 32'(tx_irq_o), 32'(v[0]));
      end

      // R6: clear pulse
      @(negedge clk) done_clr_i = 1'b1;
      @(negedge clk) done_clr_i = 1'b0;
      check(done_o == 1'b0 && tx_irq_o == 1'b0, "R6 flag cleared",
            {30'd0, done_o, tx_irq_o}, 0);

      // R7: zero length on entry
      begin
         logic low_seen = 1'b0;
         post(7, 16'h0050, 16'd0);
         log_n = 0;
         kick(NL'(1) << 7);
         repeat (60) begin
            @(negedge clk);
            if (txd_o[7] == 1'b0) low_seen = 1'b1;
         end
         check(log_n == 2, "R7 access count", 32'(log_n), 2);
         check(low_seen == 1'b0, "R7 no frame", 32'(low_seen), 0);
         check(active_o[7] == 1'b0 && done_o == 1'b1, "R7 dropped with flag",
               {30'd0, active_o[7], done_o}, 1);
         check(mem[8'h87] == 16'h0050, "R7 table untouched", 32'(mem[8'h87]), 32'h50);
      end

      // R8 R9: two lines posted together, stalling memory
      begin
         logic [7:0] a0, a1, c0, c1;
         int ta, tb2, tc, td;
         logic oa, ob, oc, od2;
         int seq [4];
         int k = 0;
         cfg_len_i   = 2'd3;
         cfg_stop2_i = 1'b0;
         mem[8'h30]  = 16'h2211;
         mem[8'h34]  = 16'h4433;
         post(2, 16'h0060, 16'd2);
         post(5, 16'h0068, 16'd2);
         stall = 1'b1;
         log_n = 0;
         kick((NL'(1) << 2) | (NL'(1) << 5));
         fork
            begin
               decode(2, 8, 1, a0, ta, oa);
               decode(2, 8, 1, a1, tb2, ob);
            end
            begin
               decode(5, 8, 1, c0, tc, oc);
               decode(5, 8, 1, c1, td, od2);
            end
         join
         repeat (20) @(negedge clk);
         stall = 1'b0;
         for (int i = 0; i < log_n; i++) begin
            if (!log_w[i] && log_a[i] >= 16'h0100 && log_a[i] < 16'h0120 && k < 4) begin
               seq[k] = int'(log_a[i] - 16'h0100) / 2;
               k++;
            end
         end
         check(k == 4, "R8 service count", 32'(k), 4);
         check(seq[0] == 2 && seq[1] == 5 && seq[2] == 2 && seq[3] == 5, "R8 rotation",
               32'({seq[0][7:0], seq[1][7:0], seq[2][7:0], seq[3][7:0]}), 32'h02050205);
         check(a0 == 8'h11 && a1 == 8'h22 && c0 == 8'h33 && c1 == 8'h44,
               "R9 data under stall", {a0, a1, c0, c1}, 32'h11223344);
         check(oa && ob && oc && od2, "R9 framing under stall", 32'({oa, ob, oc, od2}), 15);
      end

      // R11: set pulse meets the zero-length clear
      begin
         int w = 0;
         post(3, 16'h0070, 16'd1);
         @(negedge clk) done_clr_i = 1'b1;
         @(negedge clk) done_clr_i = 1'b0;
         kick(NL'(1) << 3);
         while (!(mem_req_o && mem_we_o && mem_addr_o == 16'h0126) && w < 500) begin
            @(negedge clk);
            w++;
         end
         check(mem_wdata_o == 16'd0, "R11 zero length write seen", 32'(mem_wdata_o), 0);
         act_set_i = NL'(1) << 3;
         @(negedge clk) act_set_i = '0;
         check(active_o[3] == 1'b1, "R11 line stays pending", 32'(active_o[3]), 1);
         check(done_o == 1'b1, "R11 completion raised", 32'(done_o), 1);
         repeat (200) @(negedge clk);
         check(active_o[3] == 1'b0 && mem[8'h93] == 16'd0, "R11 refetch drops line",
               {15'd0, active_o[3], mem[8'h93]}, 0);
      end

      // R10: break hold
      @(negedge clk) brk_i = NL'(1) << 4;
      repeat (3) @(negedge clk);
      check(txd_o[4] == 1'b0, "R10 break low", 32'(txd_o[4]), 0);
      check(txd_o[5] == 1'b1, "R10 neighbour idle", 32'(txd_o[5]), 1);
      @(negedge clk) brk_i = '0;
      @(negedge clk);
      check(txd_o[4] == 1'b1, "R10 break released", 32'(txd_o[4]), 1);

      summary();
   end
endmodule